// File: doc/BRIEF.md
# Two-Wire Bus Activity Watchdog

This block supervises a host processor by listening to its two-wire serial bus. The host does not need a dedicated kick pin. Any bus transaction that opens with a start condition and closes with a stop condition counts as a sign of life and restarts an interval counter. If no such transaction completes before the counter reaches the selected limit, the watchdog output is raised. It then stays raised until the host completes another transaction.

The clock and data lines arrive already synchronized to the block clock. A free-running tick enable sets the time base, so the three interval limits are counts of tick cycles. A two-bit select, held in a register elsewhere, picks a short, medium or long interval, or turns the watchdog off. The host can change the select at any time. A change starts the interval afresh under the new limit. The block has no data stream, so all of its pins are plain level or pulse signals.

Top module: `bus_watchdog`

## Requirements
- R1: While rst_n is low, and on the first cycle after it, wdo_o is low, the start/stop history is cleared, and no start is pending.
- R2: A start is seen when sda_i goes from 1 to 0 between two consecutive samples and scl_i is 1 in both. A stop is seen when sda_i goes from 0 to 1 under the same clock condition. An sda_i change while scl_i is 0 is neither.
- R3: A stop seen while a start is pending is a valid restart. At that clock edge it zeroes the interval count and drives wdo_o low, and it clears the pending start.
- R4: The limit is LIM_SHORT ticks for sel_i = 2'b00, LIM_MID for 2'b01 and LIM_LONG for 2'b10. wdo_o rises at the clock edge that carries the limit-th tick after the last restart, and not before.
- R5: Once high, wdo_o stays high until a valid restart or the off setting.
- R6: A stop with no pending start has no effect on wdo_o or on the count. A start alone only makes a start pending, and the next stop then restarts the counter.
- R7: The count advances only on cycles where tick_i is 1.
- R8: With sel_i = 2'b11 the count is held at zero, and wdo_o is low from the next clock edge for as long as the setting lasts.
- R9: When sel_i changes to an enabled code, the count restarts from zero at that edge, so the timeout is measured from the change. The level of wdo_o is left as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Synchronized bus clock line |
| sda_i | input | 1 | Synchronized bus data line |
| sel_i | input | 2 | Interval select: 00 short, 01 medium, 10 long, 11 off |
| tick_i | input | 1 | Time-base enable; one count per high cycle |
| wdo_o | output | 1 | Watchdog timeout, active high |

## Verification
The bench times each interval to the exact cycle, one cycle before and at the edge where wdo_o must rise. A counter that is off by one, or that counts cycles with tick_i low, misses one of these two samples. It sends a lone stop, data toggles under a low clock line, and a start held open across the whole interval. A detector that treats any edge as activity, or that restarts on the start rather than the stop, would clear wdo_o or postpone the timeout. It also checks that a select change restarts the interval while the output keeps its level, and that the off setting forces the output low. A design that ignored either would fire at the old deadline or stay stuck high.

// File: rtl/bwd_pkg.sv
package bwd_pkg;

  typedef enum logic [1:0] {
    WIN_SHORT = 2'b00,
    WIN_MID   = 2'b01,
    WIN_LONG  = 2'b10,
    WIN_OFF   = 2'b11
  } win_sel_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/bwd_cond_detect.sv
module bwd_cond_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o
);

  // Previous sample of both lines; idle bus is high on both.
  logic scl_q;
  logic sda_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  logic clk_line_high;
  assign clk_line_high = scl_q & scl_i;

  assign start_o = clk_line_high &  sda_q & ~sda_i;
  assign stop_o  = clk_line_high & ~sda_q &  sda_i;

endmodule

// File: rtl/bwd_arm_seq.sv
module bwd_arm_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic stop_i,
  output logic armed_o,
  output logic kick_o
);

  logic armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       armed_q <= 1'b0;
    else if (start_i) armed_q <= 1'b1;
    else if (stop_i)  armed_q <= 1'b0;
  end

  assign armed_o = armed_q;
  // A transaction completes only when its stop follows a pending start.
  assign kick_o  = stop_i & armed_q;

endmodule

// File: rtl/bwd_interval_cnt.sv
module bwd_interval_cnt
  import bwd_pkg::*;
#(
  parameter int LIM_SHORT = 25,
  parameter int LIM_MID   = 200,
  parameter int LIM_LONG  = 1400
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel_i,
  input  logic       kick_i,
  input  logic       tick_i,
  output logic       wdo_o
);

  localparam int LIM_MAX = max3(LIM_SHORT, LIM_MID, LIM_LONG);
  localparam int CNT_W   = $clog2(LIM_MAX + 1);

  win_sel_e         sel;
  win_sel_e         sel_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_cnt;
  logic             wdo_q;

  assign sel = win_sel_e'(sel_i);

  // Terminal count for the selected window.
  always_comb begin
    case (sel)
      WIN_SHORT: last_cnt = CNT_W'(LIM_SHORT - 1);
      WIN_MID:   last_cnt = CNT_W'(LIM_MID - 1);
      WIN_LONG:  last_cnt = CNT_W'(LIM_LONG - 1);
      default:   last_cnt = '0;
    endcase
  end

  // Priority: off, completed transaction, select change, tick.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      wdo_q <= 1'b0;
      sel_q <= WIN_OFF;
    end else begin
      sel_q <= sel;
      if (sel == WIN_OFF) begin
        cnt_q <= '0;
        wdo_q <= 1'b0;
      end else if (kick_i) begin
        cnt_q <= '0;
        wdo_q <= 1'b0;
      end else if (sel != sel_q) begin
        cnt_q <= '0;
      end else if (tick_i && !wdo_q) begin
        if (cnt_q == last_cnt) wdo_q <= 1'b1;
        else                   cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign wdo_o = wdo_q;

endmodule

// File: rtl/bus_watchdog.sv
module bus_watchdog #(
  parameter int LIM_SHORT = 25,
  parameter int LIM_MID   = 200,
  parameter int LIM_LONG  = 1400
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] sel_i,
  input  logic       tick_i,
  output logic       wdo_o
);

  logic start_det;
  logic stop_det;
  logic armed;
  logic kick;

  bwd_cond_detect u_detect (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_i   (scl_i),
    .sda_i   (sda_i),
    .start_o (start_det),
    .stop_o  (stop_det)
  );

  bwd_arm_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_det),
    .stop_i  (stop_det),
    .armed_o (armed),
    .kick_o  (kick)
  );

  bwd_interval_cnt #(
    .LIM_SHORT (LIM_SHORT),
    .LIM_MID   (LIM_MID),
    .LIM_LONG  (LIM_LONG)
  ) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel_i  (sel_i),
    .kick_i (kick),
    .tick_i (tick_i),
    .wdo_o  (wdo_o)
  );

endmodule

// File: rtl/bwd_checker.sv
module bwd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] sel_i,
  input logic       tick_i,
  input logic       wdo_o,
  input logic       kick,
  input logic       start_det,
  input logic       armed
);

  // R8: off setting forces the output low
  p_off_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sel_i == 2'b11 |=> !wdo_o);

  // R3: completed transaction clears the output
  p_kick_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> !wdo_o);

  // R5: timeout output is sticky
  p_wdo_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wdo_o && !kick && sel_i != 2'b11) |=> wdo_o);

  // R7: output can only rise on a tick cycle
  p_rise_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdo_o) |-> $past(tick_i));

  // R6: a detected start leaves a pending start behind
  p_start_arms_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> armed);

endmodule

bind bus_watchdog bwd_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sel_i     (sel_i),
  .tick_i    (tick_i),
  .wdo_o     (wdo_o),
  .kick      (kick),
  .start_det (start_det),
  .armed     (armed)
);

// File: tb/bus_watchdog_tb.sv
module bus_watchdog_tb;

  localparam int LS = 25;
  localparam int LM = 200;
  localparam int LL = 1400;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       sda = 1'b1;
  logic       tick = 1'b1;
  logic [1:0] sel = 2'b00;
  logic       wdo;

  always #5 clk = ~clk;

  bus_watchdog #(.LIM_SHORT(LS), .LIM_MID(LM), .LIM_LONG(LL)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
    .sel_i(sel), .tick_i(tick), .wdo_o(wdo)
  );

  typedef struct {
    int    cyc;
    logic  val;
    string tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   checks = 0;
  int   fails = 0;
  bit   done = 1'b0;

  // Monitor: sample after each rising edge and pop due items.
  always begin
    @(posedge clk);
    #1;
    cyc++;
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (e.cyc != cyc || wdo !== e.val) begin
        fails++;
        $display("FAIL %s: wdo=%b expected %b at cycle %0d", e.tag, wdo, e.val, cyc);
      end
    end
  end

  task automatic expect_in(input int n, input logic v, input string tag);
    exp_t e;
    e.cyc = cyc + n;
    e.val = v;
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic expect_at(input int abs_cyc, input logic v, input string tag);
    exp_t e;
    e.cyc = abs_cyc;
    e.val = v;
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_cond;
    @(negedge clk) sda = 1'b0;
  endtask

  task automatic scl_pulse;
    @(negedge clk) scl = 1'b0;
    @(negedge clk) scl = 1'b1;
  endtask

  task automatic stop_cond;
    @(negedge clk) sda = 1'b1;
  endtask

  // Start, clock low, clock high, stop; returns at the stop drive.
  task automatic kick_seq;
    start_cond();
    scl_pulse();
    stop_cond();
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    int c0;
    int c1;
    // R1: reset state
    expect_in(2, 1'b0, "R1 reset");
    idle(3);
    rst_n = 1'b1;
    expect_in(1, 1'b0, "R1 after release");
    idle(2);

    // R3, R4: short window from a valid restart
    kick_seq();
    expect_in(LS, 1'b0, "R4 short early");
    expect_in(LS + 1, 1'b1, "R4 short timeout");
    idle(LS + 2);

    // R5: stays high
    expect_in(60, 1'b1, "R5 sticky");
    idle(61);

    // R6: stop without start
    @(negedge clk) scl = 1'b0;
    @(negedge clk) sda = 1'b0;
    @(negedge clk) scl = 1'b1;
    @(negedge clk) sda = 1'b1;
    expect_in(1, 1'b1, "R6 lone stop");
    expect_in(5, 1'b1, "R6 lone stop later");
    idle(6);

    // R2: data toggles under low clock are not conditions
    @(negedge clk) scl = 1'b0;
    @(negedge clk) sda = 1'b0;
    @(negedge clk) sda = 1'b1;
    @(negedge clk) sda = 1'b0;
    @(negedge clk) scl = 1'b1;
    @(negedge clk) sda = 1'b1;
    expect_in(2, 1'b1, "R2 low-clock toggles");
    idle(3);

    // R3: valid restart clears the output
    kick_seq();
    expect_in(1, 1'b0, "R3 clear");
    idle(2);

    // R6: start alone does not restart the interval
    kick_seq();
    c0 = cyc;
    idle(8);
    start_cond();
    scl_pulse();
    expect_at(c0 + LS, 1'b0, "R6 start only early");
    expect_at(c0 + LS + 1, 1'b1, "R6 start only timeout");
    while (cyc < c0 + LS + 3) @(negedge clk);
    stop_cond();
    expect_in(1, 1'b0, "R6 pending start then stop");
    idle(2);

    // R7: no count without tick
    @(negedge clk) tick = 1'b0;
    kick_seq();
    expect_in(50, 1'b0, "R7 no tick");
    expect_in(100, 1'b0, "R7 no tick long");
    idle(101);
    @(negedge clk) tick = 1'b1;
    expect_in(LS - 1, 1'b0, "R7 tick early");
    expect_in(LS, 1'b1, "R7 tick timeout");
    idle(LS + 1);

    // R9: select change keeps the output level
    @(negedge clk) sel = 2'b01;
    expect_in(1, 1'b1, "R9 level kept");
    idle(2);

    // R4: medium window
    kick_seq();
    expect_in(LM, 1'b0, "R4 mid early");
    expect_in(LM + 1, 1'b1, "R4 mid timeout");
    idle(LM + 2);

    // R4: long window
    @(negedge clk) sel = 2'b10;
    kick_seq();
    expect_in(LL, 1'b0, "R4 long early");
    expect_in(LL + 1, 1'b1, "R4 long timeout");
    idle(LL + 2);

    // R9: select change restarts the interval
    @(negedge clk) sel = 2'b00;
    kick_seq();
    c0 = cyc;
    idle(15);
    @(negedge clk) sel = 2'b01;
    c1 = cyc;
    expect_at(c0 + LS + 1, 1'b0, "R9 old deadline");
    expect_at(c1 + LM, 1'b0, "R9 new early");
    expect_at(c1 + LM + 1, 1'b1, "R9 new timeout");
    idle(LM + 2);

    // R8: off setting
    @(negedge clk) sel = 2'b11;
    expect_in(1, 1'b0, "R8 off clears");
    expect_in(2000, 1'b0, "R8 off stays low");
    idle(2001);

    // R9: off to short restarts from the change
    @(negedge clk) sel = 2'b00;
    expect_in(LS, 1'b0, "R9 enable early");
    expect_in(LS + 1, 1'b1, "R9 enable timeout");
    idle(LS + 2);

    if (q.size() != 0) begin
      fails++;
      $display("FAIL pending: %0d expected items not sampled, expected 0", q.size());
    end
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      summary();
      $finish;
    end
  end

endmodule